// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block holds the stack pointer of a small 8-bit processor and runs the memory cycles for every stack operation. The processor issues one command at a time: push a byte, pop a byte, subroutine call, interrupt entry, return, or return from interrupt. The block then walks through the byte sequence for that command on a single-port byte RAM, with one byte per clock. It saves the program counter and status word that are presented at the inputs. It restores the program counter, status word or popped byte to its outputs.

The stack occupies one fixed 256-byte page of RAM. Stores write to the current slot and then move the pointer down. Loads move the pointer up and then read. The pointer wraps inside the page with no fault. A separate load path sets the pointer directly, for example to 0xFE during start-up. Instruction decode, vector fetch and the RAM itself sit outside this block. The RAM is assumed to return read data combinationally for the address presented in the same cycle.

Top module: `stk_sequencer`

## Requirements
- R1: Every stack access presents address {STACK_PAGE, low byte}, with STACK_PAGE defaulting to 0x01. `mem_we` is high only in cycles where `busy` is high.
- R2: A push (cmd_op 0) writes one byte to address low byte = SP and then decrements SP. The byte comes from `push_sel`, where 0 selects `reg_a`, 1 `reg_x`, 2 `reg_y` and 3 `psw_in`.
- R3: A pop (cmd_op 1) first increments SP and then reads address low byte = new SP. The byte read appears on `pop_data` when `done` is high.
- R4: A call (cmd_op 2) writes `pc_in[15:8]` and then `pc_in[7:0]`. SP decrements after each write.
- R5: An interrupt entry (cmd_op 3) writes `pc_in[15:8]`, then `pc_in[7:0]`, then `psw_in`. SP decrements after each of the three writes.
- R6: A return (cmd_op 4) reads the low PC byte and then the high PC byte, with a pre-increment of SP before each read. The result appears on `pc_out`.
- R7: A return from interrupt (cmd_op 5) reads the status byte into `psw_out`, then the low PC byte, then the high PC byte, with a pre-increment before each read.
- R8: SP wraps modulo 256 in both directions, and addresses never leave the stack page.
- R9: A command accepted at a clock edge (`cmd_valid` high with `busy` low) raises `busy` for exactly N cycles, where N is its byte count (1, 1, 2, 3, 2, 3). It performs one byte per cycle, then pulses `done` for one cycle as `busy` falls. Commands presented while `busy` is high, and cmd_op values 6 and 7, are ignored.
- R10: `sp_load` with `busy` low sets SP to `sp_load_val` at the next edge. If a command is also presented in that cycle, the command is ignored. `sp_load` while `busy` is high is ignored.
- R11: After reset, SP, `busy`, `done`, `pc_out`, `psw_out` and `pop_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call, 3 interrupt, 4 return, 5 return from interrupt |
| push_sel | input | 2 | Push source: 0 A, 1 X, 2 Y, 3 status |
| reg_a | input | 8 | Accumulator value for push |
| reg_x | input | 8 | X register value for push |
| reg_y | input | 8 | Y register value for push |
| psw_in | input | 8 | Status word to save |
| pc_in | input | 16 | Program counter to save |
| sp_load | input | 1 | Direct SP write request |
| sp_load_val | input | 8 | Value for direct SP write |
| mem_rdata | input | 8 | RAM read data |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| sp | output | 8 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| psw_out | output | 8 | Restored status word |
| pop_data | output | 8 | Last popped byte |

## Verification
The bench targets the pointer wrap at both page edges. One case is an interrupt entry starting at SP 0x01 that writes 0x01, 0x00 and 0xFF. Another is a pop from 0xFF that reads slot 0x00. A design that carries into the page byte, or that forgets to wrap, would address the wrong page or the wrong slot. The bench also checks the byte order of call, interrupt and both returns against its own model. A swapped order shows up as a PC with its bytes exchanged, or as a status byte read from a PC slot. Finally, it issues commands and SP loads in the middle of a sequence, and loads together with commands. A design that accepts them would corrupt SP or stretch `busy`.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int BYTE_W = 8;
    localparam int SP_W   = 8;
    localparam int PC_W   = 2 * BYTE_W;
    localparam int OP_W   = 3;
    localparam int STEP_W = 2;
    localparam int SEL_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_IRQ  = 3'd3,
        OP_RET  = 3'd4,
        OP_RETI = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        SLOT_PCL  = 2'd0,
        SLOT_PCH  = 2'd1,
        SLOT_PSW  = 2'd2,
        SLOT_DATA = 2'd3
    } stk_slot_e;

    typedef struct packed {
        logic              busy;
        logic              done;
        stk_op_e           op;
        logic [STEP_W-1:0] step;
        logic [SP_W-1:0]   sp;
        logic [PC_W-1:0]   pc_save;
        logic [BYTE_W-1:0] psw_save;
        logic [BYTE_W-1:0] data_save;
        logic [PC_W-1:0]   pc_rest;
        logic [BYTE_W-1:0] psw_rest;
        logic [BYTE_W-1:0] pop_byte;
    } stk_state_t;

    function automatic logic op_is_valid(input logic [OP_W-1:0] code);
        return code <= 3'd5;
    endfunction
endpackage

// File: rtl/stk_step_decode.sv
module stk_step_decode
    import stk_pkg::*;
(
    input  stk_op_e           op,
    input  logic [STEP_W-1:0] step,
    output logic              is_write,
    output stk_slot_e         slot,
    output logic              is_last
);
    always_comb begin
        is_write = 1'b0;
        slot     = SLOT_DATA;
        is_last  = 1'b1;
        case (op)
            OP_PUSH: begin
                is_write = 1'b1;
                slot     = SLOT_DATA;
            end
            OP_POP: begin
                slot = SLOT_DATA;
            end
            OP_CALL: begin
                is_write = 1'b1;
                slot     = (step == 2'd0) ? SLOT_PCH : SLOT_PCL;
                is_last  = (step == 2'd1);
            end
            OP_IRQ: begin
                is_write = 1'b1;
                case (step)
                    2'd0:    slot = SLOT_PCH;
                    2'd1:    slot = SLOT_PCL;
                    default: slot = SLOT_PSW;
                endcase
                is_last = (step == 2'd2);
            end
            OP_RET: begin
                slot    = (step == 2'd0) ? SLOT_PCL : SLOT_PCH;
                is_last = (step == 2'd1);
            end
            OP_RETI: begin
                case (step)
                    2'd0:    slot = SLOT_PSW;
                    2'd1:    slot = SLOT_PCL;
                    default: slot = SLOT_PCH;
                endcase
                is_last = (step == 2'd2);
            end
            default: begin
                is_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE = 8'h01
) (
    input  logic [SP_W-1:0]   sp,
    input  logic              is_write,
    output logic [PC_W-1:0]   addr,
    output logic [SP_W-1:0]   sp_next
);
    logic [SP_W-1:0] sp_up;
    logic [SP_W-1:0] sp_dn;

    assign sp_up   = sp + 8'd1;
    assign sp_dn   = sp - 8'd1;
    assign addr    = {PAGE, (is_write ? sp : sp_up)};
    assign sp_next = is_write ? sp_dn : sp_up;
endmodule

// File: rtl/stk_sequencer.sv
module stk_sequencer
    import stk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [SEL_W-1:0]  push_sel,
    input  logic [BYTE_W-1:0] reg_a,
    input  logic [BYTE_W-1:0] reg_x,
    input  logic [BYTE_W-1:0] reg_y,
    input  logic [BYTE_W-1:0] psw_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              sp_load,
    input  logic [SP_W-1:0]   sp_load_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [PC_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic [SP_W-1:0]   sp,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] psw_out,
    output logic [BYTE_W-1:0] pop_data
);
    stk_state_t q_q, st_d;

    logic            dec_write;
    logic            dec_last;
    stk_slot_e       dec_slot;
    logic [PC_W-1:0] ag_addr;
    logic [SP_W-1:0] ag_sp_next;
    logic [BYTE_W-1:0] push_byte;

    stk_step_decode u_dec (
        .op       (q_q.op),
        .step     (q_q.step),
        .is_write (dec_write),
        .slot     (dec_slot),
        .is_last  (dec_last)
    );

    stk_addr_gen #(.PAGE(STACK_PAGE)) u_agen (
        .sp       (q_q.sp),
        .is_write (dec_write),
        .addr     (ag_addr),
        .sp_next  (ag_sp_next)
    );

    always_comb begin
        case (push_sel)
            2'd0:    push_byte = reg_a;
            2'd1:    push_byte = reg_x;
            2'd2:    push_byte = reg_y;
            default: push_byte = psw_in;
        endcase
    end

    always_comb begin
        st_d      = q_q;
        st_d.done = 1'b0;
        mem_addr  = ag_addr;
        mem_we    = 1'b0;
        mem_wdata = '0;
        if (q_q.busy) begin
            if (dec_write) begin
                mem_we = 1'b1;
                case (dec_slot)
                    SLOT_PCH:  mem_wdata = q_q.pc_save[PC_W-1:BYTE_W];
                    SLOT_PCL:  mem_wdata = q_q.pc_save[BYTE_W-1:0];
                    SLOT_PSW:  mem_wdata = q_q.psw_save;
                    default:   mem_wdata = q_q.data_save;
                endcase
            end else begin
                case (dec_slot)
                    SLOT_PCH:  st_d.pc_rest[PC_W-1:BYTE_W] = mem_rdata;
                    SLOT_PCL:  st_d.pc_rest[BYTE_W-1:0]    = mem_rdata;
                    SLOT_PSW:  st_d.psw_rest               = mem_rdata;
                    default:   st_d.pop_byte               = mem_rdata;
                endcase
            end
            st_d.sp = ag_sp_next;
            if (dec_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.step = '0;
            end else begin
                st_d.step = q_q.step + 2'd1;
            end
        end else if (sp_load) begin
            st_d.sp = sp_load_val;
        end else if (cmd_valid && op_is_valid(cmd_op)) begin
            st_d.busy      = 1'b1;
            st_d.op        = stk_op_e'(cmd_op);
            st_d.step      = '0;
            st_d.pc_save   = pc_in;
            st_d.psw_save  = psw_in;
            st_d.data_save = push_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= st_d;
        end
    end

    assign busy     = q_q.busy;
    assign done     = q_q.done;
    assign sp       = q_q.sp;
    assign pc_out   = q_q.pc_rest;
    assign psw_out  = q_q.psw_rest;
    assign pop_data = q_q.pop_byte;
endmodule

// File: rtl/stk_sequencer_chk.sv
module stk_sequencer_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [7:0]  sp,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        sp_load,
    input logic [7:0]  sp_load_val
);
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_addr[15:8] == STACK_PAGE); // R1
    AST_WE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R1
    AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> mem_addr[7:0] == sp); // R2
    AST_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |=> sp == $past(sp) - 8'd1); // R8
    AST_READ_ABOVE_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |-> mem_addr[7:0] == sp + 8'd1); // R3
    AST_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> sp == $past(sp) + 8'd1); // R8
    AST_DONE_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9
    AST_IDLE_SP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sp_load) |=> sp == $past(sp)); // R9
    AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp_load) |=> (sp == $past(sp_load_val) && !busy)); // R10
endmodule

bind stk_sequencer stk_sequencer_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .sp          (sp),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val)
);

// File: tb/sim_stk_sequencer.sv
`timescale 1ns/1ps
module sim_stk_sequencer;
    localparam logic [7:0] PAGE = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  push_sel = '0;
    logic [7:0]  reg_a = '0, reg_x = '0, reg_y = '0, psw_in = '0;
    logic [15:0] pc_in = '0;
    logic        sp_load = 1'b0;
    logic [7:0]  sp_load_val = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, busy, done;
    logic [7:0]  sp, psw_out, pop_data;
    logic [15:0] pc_out;

    logic [7:0] ram [256];

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R11";

    // reference model state
    logic [7:0]  m_sp = '0;
    logic        m_busy = 1'b0, m_done = 1'b0;
    logic [15:0] m_pc = '0;
    logic [7:0]  m_psw = '0, m_pop = '0;
    int q_kind[$]; // 0 write, 1 read
    int q_val[$];  // write value or read target: 0 pcl 1 pch 2 psw 3 data

    always #2 clk = ~clk;

    assign mem_rdata = ram[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;

    stk_sequencer #(.STACK_PAGE(PAGE)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .push_sel(push_sel), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .psw_in(psw_in), .pc_in(pc_in), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy), .done(done), .sp(sp), .pc_out(pc_out),
        .psw_out(psw_out), .pop_data(pop_data)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        chk(cur_req, "sp", {8'h0, sp}, {8'h0, m_sp});
        chk("R9", "busy", {15'h0, busy}, {15'h0, m_busy});
        chk("R9", "done", {15'h0, done}, {15'h0, m_done});
        chk(cur_req, "pc_out", pc_out, m_pc);
        chk(cur_req, "psw_out", {8'h0, psw_out}, {8'h0, m_psw});
        chk(cur_req, "pop_data", {8'h0, pop_data}, {8'h0, m_pop});
    endtask

    task automatic cyc(input logic v, input logic [2:0] op, input logic [1:0] sel,
                       input logic ld, input logic [7:0] ldv);
        logic [7:0] n_sp;
        logic       n_busy, n_done;
        logic [15:0] n_pc;
        logic [7:0]  n_psw, n_pop, rd;
        logic [7:0]  src;
        cmd_valid = v; cmd_op = op; push_sel = sel; sp_load = ld; sp_load_val = ldv;
        #0.5;
        n_sp = m_sp; n_busy = m_busy; n_done = 1'b0;
        n_pc = m_pc; n_psw = m_psw; n_pop = m_pop;
        if (m_busy) begin
            chk("R1", "mem_addr page", {8'h0, mem_addr[15:8]}, {8'h0, PAGE});
            if (q_kind[0] == 0) begin
                chk(cur_req, "mem_we", {15'h0, mem_we}, 16'h1);
                chk(cur_req, "mem_addr low", {8'h0, mem_addr[7:0]}, {8'h0, m_sp});
                chk(cur_req, "mem_wdata", {8'h0, mem_wdata}, q_val[0][15:0]);
                n_sp = m_sp - 8'd1;
            end else begin
                chk(cur_req, "mem_we", {15'h0, mem_we}, 16'h0);
                n_sp = m_sp + 8'd1;
                chk(cur_req, "mem_addr low", {8'h0, mem_addr[7:0]}, {8'h0, n_sp});
                rd = ram[n_sp];
                case (q_val[0])
                    0: n_pc[7:0] = rd;
                    1: n_pc[15:8] = rd;
                    2: n_psw = rd;
                    default: n_pop = rd;
                endcase
            end
            void'(q_kind.pop_front());
            void'(q_val.pop_front());
            if (q_kind.size() == 0) begin
                n_busy = 1'b0;
                n_done = 1'b1;
            end
        end else begin
            chk("R1", "mem_we idle", {15'h0, mem_we}, 16'h0);
            if (ld) begin
                n_sp = ldv;
            end else if (v && op <= 3'd5) begin
                case (sel)
                    2'd0: src = reg_a;
                    2'd1: src = reg_x;
                    2'd2: src = reg_y;
                    default: src = psw_in;
                endcase
                n_busy = 1'b1;
                case (op)
                    3'd0: begin q_kind.push_back(0); q_val.push_back(int'(src)); end
                    3'd1: begin q_kind.push_back(1); q_val.push_back(3); end
                    3'd2: begin
                        q_kind.push_back(0); q_val.push_back(int'(pc_in[15:8]));
                        q_kind.push_back(0); q_val.push_back(int'(pc_in[7:0]));
                    end
                    3'd3: begin
                        q_kind.push_back(0); q_val.push_back(int'(pc_in[15:8]));
                        q_kind.push_back(0); q_val.push_back(int'(pc_in[7:0]));
                        q_kind.push_back(0); q_val.push_back(int'(psw_in));
                    end
                    3'd4: begin
                        q_kind.push_back(1); q_val.push_back(0);
                        q_kind.push_back(1); q_val.push_back(1);
                    end
                    default: begin
                        q_kind.push_back(1); q_val.push_back(2);
                        q_kind.push_back(1); q_val.push_back(0);
                        q_kind.push_back(1); q_val.push_back(1);
                    end
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_sp = n_sp; m_busy = n_busy; m_done = n_done;
        m_pc = n_pc; m_psw = n_psw; m_pop = n_pop;
        chk_regs();
    endtask

    task automatic idle();
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 8'h00);
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] sel);
        cyc(1'b1, op, sel, 1'b0, 8'h00);
        while (m_busy) idle();
        idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'(i * 7 + 3);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R11";
        chk_regs();

        cur_req = "R10";
        cyc(1'b0, 3'd0, 2'd0, 1'b1, 8'hFE);

        cur_req = "R2";
        reg_a = 8'h5A; reg_x = 8'h3C; reg_y = 8'hA7; psw_in = 8'h81;
        run(3'd0, 2'd0);
        run(3'd0, 2'd1);
        run(3'd0, 2'd2);
        run(3'd0, 2'd3);

        cur_req = "R3";
        repeat (4) run(3'd1, 2'd0);

        cur_req = "R4";
        pc_in = 16'h1234;
        run(3'd2, 2'd0);
        cur_req = "R6";
        pc_in = 16'h0000;
        run(3'd4, 2'd0);

        cur_req = "R5";
        pc_in = 16'hABCD; psw_in = 8'hC3;
        run(3'd3, 2'd0);
        cur_req = "R7";
        pc_in = 16'h0000; psw_in = 8'h00;
        run(3'd5, 2'd0);

        cur_req = "R9";
        pc_in = 16'h55AA; psw_in = 8'h18;
        cyc(1'b1, 3'd3, 2'd0, 1'b0, 8'h00);
        cyc(1'b1, 3'd0, 2'd0, 1'b0, 8'h00);
        cyc(1'b1, 3'd2, 2'd0, 1'b1, 8'h10);
        while (m_busy) idle();
        cyc(1'b1, 3'd6, 2'd0, 1'b0, 8'h00);
        cyc(1'b1, 3'd7, 2'd0, 1'b0, 8'h00);
        idle();
        run(3'd5, 2'd0);

        cur_req = "R10";
        cyc(1'b1, 3'd0, 2'd0, 1'b1, 8'h40);
        idle();
        idle();

        cur_req = "R8";
        cyc(1'b0, 3'd0, 2'd0, 1'b1, 8'h00);
        reg_a = 8'hE1;
        run(3'd0, 2'd0);
        run(3'd1, 2'd0);
        cyc(1'b0, 3'd0, 2'd0, 1'b1, 8'h01);
        pc_in = 16'hBEEF; psw_in = 8'h42;
        run(3'd3, 2'd0);
        pc_in = 16'h0000;
        run(3'd5, 2'd0);
        cyc(1'b0, 3'd0, 2'd0, 1'b1, 8'hFF);
        run(3'd1, 2'd0);

        cur_req = "R6";
        cyc(1'b0, 3'd0, 2'd0, 1'b1, 8'h80);
        pc_in = 16'h7E01;
        cyc(1'b1, 3'd2, 2'd0, 1'b0, 8'h00);
        while (m_busy) idle();
        cyc(1'b1, 3'd4, 2'd0, 1'b0, 8'h00);
        while (m_busy) idle();
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule